// File: doc/BRIEF.md
# Floating-Point Round-to-Integral Unit

This unit takes one IEEE 754 operand in half, single or double precision and returns the nearest integral value in the same format. A two-bit size code picks the format. The rounding direction comes from a two-bit mode input, normally driven from a control register. A truncate-select input can override that mode and force rounding toward zero. A default-NaN control picks whether NaN inputs are passed on quietened or replaced by the canonical quiet NaN.

The result is registered, so it appears one clock after the operand is accepted. It comes back zero-extended in a 64-bit result port. Half-precision results sit in bits [15:0] and single-precision results in bits [31:0]. The unit never reports inexactness, even when rounding changes the value. The only exceptions it reports are an invalid-operation flag for signalling NaNs and an undefined-operation flag for the illegal size code. Subnormal operands are rounded as ordinary values and are never flushed to zero.

Top module: `fp_round_integral`

## Requirements
- R1: `size_code` 2'b01 selects binary16, 2'b10 selects binary32 and 2'b11 selects binary64. Code 2'b00 is illegal. It raises `undef_flag`, drives an all-zero `result` and keeps `invalid_flag` low.
- R2: When `trunc_sel` is 0, `rmode` sets the direction. 2'b00 rounds to nearest with ties to even (2.5 gives 2, −3.5 gives −4). 2'b01 rounds toward +infinity, 2'b10 toward −infinity and 2'b11 toward zero.
- R3: When `trunc_sel` is 1, rounding is toward zero whatever the value of `rmode`.
- R4: A ±0 operand returns the same signed zero.
- R5: A ±infinity operand returns the same infinity.
- R6: An operand whose unbiased exponent is at least the fraction width (10, 23 or 52) is already integral and is returned unchanged.
- R7: A nonzero operand with magnitude below 1, subnormals included, returns ±0 or ±1 as the mode dictates. The result always keeps the operand's sign, so −0.3 rounded toward +infinity gives −0.
- R8: With `dflt_nan` at 0, a signalling NaN (top fraction bit 0) comes back with its top fraction bit set and raises `invalid_flag`. A quiet NaN comes back unchanged with `invalid_flag` low.
- R9: With `dflt_nan` at 1, any NaN returns the canonical quiet NaN: sign 0, exponent all ones, only the top fraction bit set. `invalid_flag` is still raised for a signalling input.
- R10: Bits of `result` above the selected format's width are zero. For binary16 this means bits [63:16].
- R11: `out_valid`, `result`, `invalid_flag` and `undef_flag` are registered and reflect the operand one clock after `in_valid` was sampled high. They are all zero in reset and in any cycle after `in_valid` was low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand present this cycle |
| size_code | input | 2 | Format select: 01 half, 10 single, 11 double, 00 illegal |
| rmode | input | 2 | Rounding direction from the control register |
| trunc_sel | input | 1 | Force rounding toward zero |
| dflt_nan | input | 1 | Return canonical quiet NaN for NaN operands |
| operand | input | 64 | Operand, right-aligned for the narrower formats |
| out_valid | output | 1 | Result valid |
| result | output | 64 | Rounded value, zero-extended above the format width |
| invalid_flag | output | 1 | Invalid operation (signalling NaN input) |
| undef_flag | output | 1 | Illegal size code was presented |

## Verification
The bench builds the unit with its fixed format set: 5/10, 8/23 and 11/52 exponent/fraction widths, all three lanes live. This lets one run cover subnormals, magnitudes just below one, ties and fully integral values in every format and every rounding mode. A real-number model in the bench rounds each operand on its own. Its results are compared cycle by cycle with the unit's output, including random operands whose exponents straddle the point where the fraction vanishes.

// File: rtl/fri_pkg.sv
package fri_pkg;

    localparam int DATA_W = 64;
    localparam int FMT_N  = 3;

    typedef enum logic [1:0] {
        RND_NEAREST = 2'b00,
        RND_UP      = 2'b01,
        RND_DOWN    = 2'b10,
        RND_ZERO    = 2'b11
    } rmode_e;

    localparam logic [1:0] SZ_ILLEGAL = 2'b00;
    localparam logic [1:0] SZ_HALF    = 2'b01;
    localparam logic [1:0] SZ_SINGLE  = 2'b10;
    localparam logic [1:0] SZ_DOUBLE  = 2'b11;

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] res;
        logic              nv;
        logic              ud;
    } out_t;

    function automatic int fmt_ew(input int idx);
        case (idx)
            0:       return 5;
            1:       return 8;
            default: return 11;
        endcase
    endfunction

    function automatic int fmt_mw(input int idx);
        case (idx)
            0:       return 10;
            1:       return 23;
            default: return 52;
        endcase
    endfunction

endpackage

// File: rtl/fri_round_decide.sv
module fri_round_decide (
    input  fri_pkg::rmode_e mode_i,
    input  logic            sign_i,
    input  logic            lost_i,
    input  logic            above_half_i,
    input  logic            at_half_i,
    input  logic            lsb_i,
    output logic            incr_o
);
    import fri_pkg::*;

    always_comb begin
        case (mode_i)
            RND_NEAREST: incr_o = above_half_i || (at_half_i && lsb_i);
            RND_UP:      incr_o = lost_i && !sign_i;
            RND_DOWN:    incr_o = lost_i && sign_i;
            default:     incr_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/fri_fmt_round.sv
module fri_fmt_round #(
    parameter int EW = 8,
    parameter int MW = 23,
    localparam int W = EW + MW + 1
) (
    input  logic [W-1:0]    x_i,
    input  fri_pkg::rmode_e mode_i,
    input  logic            dn_i,
    output logic [W-1:0]    y_o,
    output logic            nv_o
);
    localparam int BIAS = (1 << (EW - 1)) - 1;
    localparam logic [EW-1:0] BIAS_V  = EW'(BIAS);
    localparam logic [EW-1:0] INT_V   = EW'(BIAS + MW);
    localparam logic [EW-1:0] HALF_V  = EW'(BIAS - 1);
    localparam logic [EW-1:0] ONES_V  = {EW{1'b1}};
    localparam logic [MW-1:0] QBIT    = {1'b1, {(MW-1){1'b0}}};
    localparam logic [W-1:0]  CANON   = {1'b0, ONES_V, QBIT};

    logic          sgn;
    logic [EW-1:0] ex;
    logic [MW-1:0] mn;
    assign {sgn, ex, mn} = x_i;

    // mid-range datapath: exponent in [BIAS, BIAS+MW-1]
    logic [EW-1:0] sh;
    logic [MW:0]   sig, step, mask, frac, ipart, halfw, sum;
    logic          lsb, mid_up;

    always_comb begin
        sh    = INT_V - ex;
        sig   = {1'b1, mn};
        step  = (MW+1)'(1) << sh;
        mask  = step - (MW+1)'(1);
        frac  = sig & mask;
        ipart = sig & ~mask;
        halfw = step >> 1;
        lsb   = |(sig & step);
    end

    fri_round_decide u_mid_dec (
        .mode_i       (mode_i),
        .sign_i       (sgn),
        .lost_i       (frac != '0),
        .above_half_i (frac > halfw),
        .at_half_i    (frac == halfw),
        .lsb_i        (lsb),
        .incr_o       (mid_up)
    );

    assign sum = ipart + (mid_up ? step : '0);

    // magnitude below one
    logic tiny_up;

    fri_round_decide u_tiny_dec (
        .mode_i       (mode_i),
        .sign_i       (sgn),
        .lost_i       (1'b1),
        .above_half_i ((ex == HALF_V) && (mn != '0)),
        .at_half_i    ((ex == HALF_V) && (mn == '0)),
        .lsb_i        (1'b0),
        .incr_o       (tiny_up)
    );

    always_comb begin
        y_o  = x_i;
        nv_o = 1'b0;
        if (ex == ONES_V) begin
            if (mn != '0) begin
                nv_o = !mn[MW-1];
                y_o  = dn_i ? CANON : {sgn, ex, mn | QBIT};
            end
        end else if (ex >= INT_V) begin
            y_o = x_i;
        end else if (ex < BIAS_V) begin
            if ((ex != '0) || (mn != '0)) begin
                y_o = tiny_up ? {sgn, BIAS_V, {MW{1'b0}}}
                              : {sgn, {EW{1'b0}}, {MW{1'b0}}};
            end
        end else begin
            if (!sum[MW]) begin
                y_o = {sgn, ex + EW'(1), {MW{1'b0}}};
            end else begin
                y_o = {sgn, ex, sum[MW-1:0]};
            end
        end
    end

endmodule

// File: rtl/fp_round_integral.sv
module fp_round_integral (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [1:0]  size_code,
    input  logic [1:0]  rmode,
    input  logic        trunc_sel,
    input  logic        dflt_nan,
    input  logic [63:0] operand,
    output logic        out_valid,
    output logic [63:0] result,
    output logic        invalid_flag,
    output logic        undef_flag
);
    import fri_pkg::*;

    rmode_e eff_mode;
    assign eff_mode = trunc_sel ? RND_ZERO : rmode_e'(rmode);

    logic [DATA_W-1:0] lane_res [FMT_N];
    logic              lane_nv  [FMT_N];

    for (genvar g = 0; g < FMT_N; g++) begin : g_fmt
        localparam int EWG = fmt_ew(g);
        localparam int MWG = fmt_mw(g);
        localparam int WG  = EWG + MWG + 1;
        logic [WG-1:0] y;
        logic          nv;
        fri_fmt_round #(.EW(EWG), .MW(MWG)) u_fmt (
            .x_i    (operand[WG-1:0]),
            .mode_i (eff_mode),
            .dn_i   (dflt_nan),
            .y_o    (y),
            .nv_o   (nv)
        );
        assign lane_res[g] = DATA_W'(y);
        assign lane_nv[g]  = nv;
    end

    out_t state_d, state_q;

    always_comb begin
        state_d     = '0;
        state_d.vld = in_valid;
        if (in_valid) begin
            case (size_code)
                SZ_HALF: begin
                    state_d.res = lane_res[0];
                    state_d.nv  = lane_nv[0];
                end
                SZ_SINGLE: begin
                    state_d.res = lane_res[1];
                    state_d.nv  = lane_nv[1];
                end
                SZ_DOUBLE: begin
                    state_d.res = lane_res[2];
                    state_d.nv  = lane_nv[2];
                end
                default: state_d.ud = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid    = state_q.vld;
    assign result       = state_q.res;
    assign invalid_flag = state_q.nv;
    assign undef_flag   = state_q.ud;

endmodule

// File: rtl/fri_checker.sv
module fri_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [1:0]  size_code,
    input logic [63:0] operand,
    input logic        out_valid,
    input logic [63:0] result,
    input logic        invalid_flag,
    input logic        undef_flag
);
    logic armed_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    assert_valid_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> (out_valid == $past(in_valid)));

    assert_illegal_size_R1: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && $past(in_valid && size_code == 2'b00)
        |-> undef_flag && (result == 64'd0) && !invalid_flag);

    assert_half_lane_R10: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && $past(in_valid && size_code == 2'b01) |-> (result[63:16] == 48'd0));

    assert_zero_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && $past(in_valid && size_code == 2'b11 && operand[62:0] == 63'd0)
        |-> (result == $past(operand)));

    assert_inf_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && $past(in_valid && size_code == 2'b11 && operand[62:52] == 11'h7FF
                         && operand[51:0] == 52'd0)
        |-> (result == $past(operand)) && !invalid_flag);

    assert_invalid_only_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        invalid_flag |-> out_valid && !undef_flag);

endmodule

bind fp_round_integral fri_checker u_fri_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .size_code    (size_code),
    .operand      (operand),
    .out_valid    (out_valid),
    .result       (result),
    .invalid_flag (invalid_flag),
    .undef_flag   (undef_flag)
);

// File: tb/fp_round_integral_bench.sv
module fp_round_integral_bench;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  size_code = 2'b00;
    logic [1:0]  rmode = 2'b00;
    logic        trunc_sel = 1'b0;
    logic        dflt_nan = 1'b0;
    logic [63:0] operand = 64'd0;
    logic        out_valid;
    logic [63:0] result;
    logic        invalid_flag;
    logic        undef_flag;

    int checks = 0;
    int errors = 0;
    bit running = 1'b0;

    typedef struct {
        bit          vld;
        logic [63:0] res;
        bit          nv;
        bit          ud;
        string       tag;
    } exp_t;

    exp_t pend[$];

    fp_round_integral u_fp_round_integral (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .size_code(size_code),
        .rmode(rmode), .trunc_sel(trunc_sel), .dflt_nan(dflt_nan), .operand(operand),
        .out_valid(out_valid), .result(result), .invalid_flag(invalid_flag),
        .undef_flag(undef_flag)
    );

    always #10 clk = ~clk;

    // ---------------- reference model ----------------
    function automatic real to_real(input logic [63:0] x, input int ew, input int mw);
        int bias = (1 << (ew - 1)) - 1;
        longint unsigned m = x & ((64'd1 << mw) - 1);
        int e = int'((x >> mw) & ((64'd1 << ew) - 1));
        bit s = x[ew + mw];
        real r;
        if (e == 0) r = real'(m) * (2.0 ** (1 - bias - mw));
        else        r = (2.0 ** mw + real'(m)) * (2.0 ** (e - bias - mw));
        return s ? -r : r;
    endfunction

    function automatic real rnd(input real r, input int md);
        real f = $floor(r);
        real d = r - f;
        case (md)
            0: begin
                if (d > 0.5) return f + 1.0;
                if (d == 0.5 && ($floor(f / 2.0) * 2.0 != f)) return f + 1.0;
                return f;
            end
            1: return $ceil(r);
            2: return f;
            default: return (r < 0.0) ? $ceil(r) : f;
        endcase
    endfunction

    function automatic logic [63:0] from_real(input real q, input bit s, input int ew, input int mw);
        int bias = (1 << (ew - 1)) - 1;
        logic [63:0] d, ee, mm;
        if (q == 0.0) return 64'(s) << (ew + mw);
        d  = $realtobits(q < 0.0 ? -q : q);
        ee = 64'(int'(d[62:52]) - 1023 + bias);
        mm = {12'd0, d[51:0]} >> (52 - mw);
        return (64'(s) << (ew + mw)) | (ee << mw) | mm;
    endfunction

    function automatic exp_t model(input bit v, input logic [1:0] sz, input logic [1:0] md,
                                   input bit tr, input bit dn, input logic [63:0] op,
                                   input string tag);
        exp_t e;
        int ew, mw, eff;
        logic [63:0] x, m, ex, ones;
        bit s;
        e.vld = v; e.res = 64'd0; e.nv = 1'b0; e.ud = 1'b0; e.tag = tag;
        if (!v) return e;
        if (sz == 2'b00) begin
            e.ud = 1'b1;
            return e;
        end
        ew = (sz == 2'b01) ? 5 : (sz == 2'b10) ? 8 : 11;
        mw = (sz == 2'b01) ? 10 : (sz == 2'b10) ? 23 : 52;
        x  = (sz == 2'b11) ? op : (op & ((64'd1 << (ew + mw + 1)) - 1));
        m  = x & ((64'd1 << mw) - 1);
        ones = (64'd1 << ew) - 1;
        ex = (x >> mw) & ones;
        s  = x[ew + mw];
        eff = tr ? 3 : int'(md);
        if (ex == ones) begin
            e.res = x;
            if (m != 0) begin
                e.nv  = ((m >> (mw - 1)) & 1) == 0;
                e.res = dn ? ((ones << mw) | (64'd1 << (mw - 1))) : (x | (64'd1 << (mw - 1)));
            end
        end else begin
            e.res = from_real(rnd(to_real(x, ew, mw), eff), s, ew, mw);
        end
        return e;
    endfunction

    // ---------------- driver ----------------
    task automatic drive(input bit v, input logic [1:0] sz, input logic [1:0] md, input bit tr,
                         input bit dn, input logic [63:0] op, input string tag);
        @(negedge clk);
        in_valid = v; size_code = sz; rmode = md; trunc_sel = tr; dflt_nan = dn; operand = op;
        pend.push_back(model(v, sz, md, tr, dn, op, tag));
    endtask

    task automatic idle();
        drive(1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 64'd0, "R11");
    endtask

    // ---------------- comparator ----------------
    always @(posedge clk) begin
        #1;
        if (running && pend.size() > 0) begin
            exp_t e;
            e = pend.pop_front();
            checks++;
            if (out_valid !== e.vld || result !== e.res || invalid_flag !== e.nv ||
                undef_flag !== e.ud) begin
                errors++;
                $display("FAIL %s: vld %b res %h nv %b ud %b, expected vld %b res %h nv %b ud %b",
                         e.tag, out_valid, result, invalid_flag, undef_flag,
                         e.vld, e.res, e.nv, e.ud);
            end
        end
    end

    initial begin : watchdog
        #(200000 * 20);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || result !== 64'd0 || invalid_flag !== 1'b0 || undef_flag !== 1'b0) begin
            errors++;
            $display("FAIL R11 reset: vld %b res %h nv %b ud %b, expected all zero",
                     out_valid, result, invalid_flag, undef_flag);
        end
        rst_n = 1'b1;
        @(negedge clk);
        running = 1'b1;

        // R2 ties and directions, single and double
        for (int md = 0; md < 4; md++) begin
            drive(1, 2'b10, 2'(md), 0, 0, 64'h4020_0000, "R2");             // 2.5
            drive(1, 2'b10, 2'(md), 0, 0, 64'hC060_0000, "R2");             // -3.5
            drive(1, 2'b10, 2'(md), 0, 0, 64'h3FC0_0000, "R2");             // 1.5
            drive(1, 2'b11, 2'(md), 0, 0, 64'h4004_0000_0000_0000, "R2");   // 2.5
            drive(1, 2'b11, 2'(md), 0, 0, 64'hC00C_0000_0000_0000, "R2");   // -3.5
            drive(1, 2'b01, 2'(md), 0, 0, 64'h4100, "R2");                  // 2.5 half
            drive(1, 2'b01, 2'(md), 0, 0, 64'h4300, "R2");                  // 3.5 half
            // R7 below one
            drive(1, 2'b10, 2'(md), 0, 0, 64'hBE99_999A, "R7");             // -0.3
            drive(1, 2'b10, 2'(md), 0, 0, 64'h3F00_0000, "R7");             // 0.5
            drive(1, 2'b10, 2'(md), 0, 0, 64'hBF00_0000, "R7");             // -0.5
            drive(1, 2'b11, 2'(md), 0, 0, 64'h3FE6_6666_6666_6666, "R7");   // 0.7
            drive(1, 2'b10, 2'(md), 0, 0, 64'h0000_0001, "R7");             // subnormal
            drive(1, 2'b01, 2'(md), 0, 0, 64'hB4CD, "R7");                  // -0.3 half
            // R3 truncation override
            drive(1, 2'b10, 2'(md), 1, 0, 64'h402C_CCCD, "R3");             // 2.7
            drive(1, 2'b11, 2'(md), 1, 0, 64'hC00C_0000_0000_0000, "R3");   // -3.5
        end
        idle();

        // R4 zeros, R5 infinities
        drive(1, 2'b11, 2'b01, 0, 0, 64'h8000_0000_0000_0000, "R4");
        drive(1, 2'b10, 2'b10, 0, 0, 64'h0000_0000, "R4");
        drive(1, 2'b01, 2'b01, 0, 0, 64'h8000, "R4");
        drive(1, 2'b11, 2'b00, 0, 0, 64'hFFF0_0000_0000_0000, "R5");
        drive(1, 2'b10, 2'b01, 0, 0, 64'h7F80_0000, "R5");
        drive(1, 2'b01, 2'b10, 0, 0, 64'hFC00, "R5");

        // R6 already integral
        drive(1, 2'b11, 2'b01, 0, 0, 64'h4340_0000_0000_0001, "R6");
        drive(1, 2'b10, 2'b10, 0, 0, 64'h4B00_0001, "R6");
        drive(1, 2'b01, 2'b00, 0, 0, 64'h7BFF, "R6");

        // R8 / R9 NaNs
        drive(1, 2'b11, 2'b00, 0, 0, 64'h7FF0_0000_0000_0001, "R8");
        drive(1, 2'b11, 2'b00, 0, 0, 64'hFFF8_0000_0000_1234, "R8");
        drive(1, 2'b10, 2'b00, 0, 0, 64'hFF80_0005, "R8");
        drive(1, 2'b01, 2'b00, 0, 0, 64'h7C01, "R8");
        drive(1, 2'b11, 2'b00, 0, 1, 64'hFFF0_0000_0000_0001, "R9");
        drive(1, 2'b10, 2'b00, 0, 1, 64'hFFC0_0001, "R9");
        drive(1, 2'b01, 2'b11, 0, 1, 64'hFC05, "R9");

        // R1 illegal size, R10 upper lanes masked
        drive(1, 2'b00, 2'b00, 0, 0, 64'h4004_0000_0000_0000, "R1");
        idle();
        drive(1, 2'b01, 2'b00, 0, 0, 64'hFFFF_FFFF_FFFF_3E00, "R10");
        drive(1, 2'b10, 2'b01, 0, 0, 64'hFFFF_FFFF_3FC0_0000, "R10");
        idle();

        // random operands near the integral boundary, all formats and modes
        for (int n = 0; n < 1200; n++) begin
            logic [63:0] r64;
            logic [1:0]  sz;
            int ew, mw, bias;
            logic [63:0] ex;
            sz   = 2'(1 + (n % 3));
            ew   = (sz == 2'b01) ? 5 : (sz == 2'b10) ? 8 : 11;
            mw   = (sz == 2'b01) ? 10 : (sz == 2'b10) ? 23 : 52;
            bias = (1 << (ew - 1)) - 1;
            r64  = {$random, $random};
            ex   = 64'(bias - 3 + ($unsigned($random) % (mw + 6)));
            r64  = (r64 & ((64'd1 << mw) - 1)) | (ex << mw) | (64'(r64[63]) << (ew + mw));
            drive(1, sz, 2'((n / 3) % 4), (n % 17) == 0, 0, r64, "R2");
            if ((n % 50) == 0) idle();
        end

        idle();
        idle();
        wait (pend.size() == 0);
        @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule